// File: doc/BRIEF.md
# Strap-Pin Address and Configuration Decoder

The decoder works out how each of two strap pins is wired on the board. A pin can be tied to ground, tied to the supply, tied to the serial data line or tied to the serial clock line. It watches every transmission on a two-wire bus, whichever device that transmission is aimed at. During the transmission it compares each synchronised strap level with SDA and SCL on every clock. When the STOP condition arrives, it commits a 2-bit connection code for each pin. Because the decoder learns again on every transmission, a board can change its strapping without a power cycle.

Before the first complete transmission after reset there is nothing to correlate against. Each pin's code then follows the pin's live level. A pin tied to SDA or SCL reads high while the bus idles, so it shows as supply-tied. From the two codes the block forms four slave-address bits. It also forms two 4-bit configuration vectors, each bit driving one port: input pull-up enables and output power-up defaults. Each pin controls a group of two ports. The port logic that owns the output register loads the default vector only at its reset. The pull-up enables follow the current code at all times.

The bus tracker has two states. ST_IDLE waits for a START and moves to ST_WINDOW when one arrives. ST_WINDOW keeps correlating. A repeated START in ST_WINDOW restarts the window, and the block stays in ST_WINDOW. A STOP in ST_WINDOW commits the codes and returns the block to ST_IDLE. A STOP seen in ST_IDLE is ignored.

Top module: `strap_addr_decoder`

## Requirements
- R1: After reset and before the first committed window, each pin's code is 01 when the pin reads high and 00 when it reads low.
- R2: A START opens a correlation window. A START is SDA falling while SCL is high on both the current and the previous clock. A STOP closes the window. A STOP is SDA rising while SCL is high on both clocks. Codes change only on the clock edge that samples the STOP, and they hold steady while the window is open.
- R3: A pin that equals SDA on every sample of the window, including the START and STOP samples, is committed as code 10, provided SDA changed during the window.
- R4: A pin that equals SCL on every sample, where SCL changed, and that does not qualify for code 10 is committed as code 11.
- R5: Any other pin is committed with its level at the STOP sample: 01 if high, 00 if low. A pin that follows SCL through a window with no SCL pulse is therefore committed as 01.
- R6: addr_o[3:2] holds the code of strap pin 1 and addr_o[1:0] holds the code of strap pin 0.
- R7: pullup_en_o[1:0] and out_dflt_o[1:0] both equal 11 when pin 0's code is not 00, and 00 when it is. Bits [3:2] follow pin 1 in the same way.
- R8: A repeated START inside a window discards the samples gathered so far and starts a new window. A STOP with no open window leaves every output unchanged.
- R9: An active-low reset returns the block to the unlearned state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Synchronised serial data line |
| scl_i | input | 1 | Synchronised serial clock line |
| strap_i | input | 2 | Synchronised strap pin levels (bit 0 = pin 0, bit 1 = pin 1) |
| addr_o | output | 4 | Slave-address bits A3..A0 |
| pullup_en_o | output | 4 | Input pull-up enables, two per strap pin |
| out_dflt_o | output | 4 | Output power-up defaults, two per strap pin |

## Verification
The assertions check on every cycle that:
- codes move only on a cycle that committed a STOP;
- the tracker enters the window only through a START;
- no bus-tied code appears before learning;
- both members of a port group, and the two configuration vectors, always agree.

Only the bench scenarios can show that the committed code is the right one. Those scenarios cover:
- pins wired to SDA, to SCL, to the supply and to ground;
- a START followed directly by a STOP;
- a repeated START;
- a stray STOP;
- a return to the unlearned state through reset.

Each scenario is compared cycle by cycle against a queue-based reference model.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [1:0] {
        TIE_GND = 2'b00,
        TIE_SUP = 2'b01,
        TIE_SDA = 2'b10,
        TIE_SCL = 2'b11
    } pin_tie_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_WINDOW = 1'b1
    } bus_state_e;

    function automatic pin_tie_e classify_tie(
        input logic sda_all, input logic sda_moved,
        input logic scl_all, input logic scl_moved,
        input logic level
    );
        if (sda_all && sda_moved)      return TIE_SDA;
        else if (scl_all && scl_moved) return TIE_SCL;
        else if (level)                return TIE_SUP;
        else                           return TIE_GND;
    endfunction

endpackage

// File: rtl/strap_bus_tracker.sv
module strap_bus_tracker
    import strap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sda_i,
    input  logic scl_i,
    output logic start_o,
    output logic commit_o,
    output logic in_win_o,
    output logic sda_chg_o,
    output logic scl_chg_o
);

    bus_state_e state_q, state_d;
    logic       sda_d, scl_d;
    logic       start_cond, stop_cond;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_d <= 1'b1;
            scl_d <= 1'b1;
        end else begin
            sda_d <= sda_i;
            scl_d <= scl_i;
        end
    end

    assign start_cond = scl_i & scl_d & sda_d & ~sda_i;
    assign stop_cond  = scl_i & scl_d & ~sda_d & sda_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_cond) state_d = ST_WINDOW;
            ST_WINDOW: if (stop_cond)  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        start_o   = start_cond;
        commit_o  = 1'b0;
        in_win_o  = 1'b0;
        sda_chg_o = sda_i ^ sda_d;
        scl_chg_o = scl_i ^ scl_d;
        unique case (state_q)
            ST_IDLE: ;
            ST_WINDOW: begin
                in_win_o = 1'b1;
                commit_o = stop_cond;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/strap_pin_correlator.sv
module strap_pin_correlator
    import strap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       sda_i,
    input  logic       scl_i,
    input  logic       start_i,
    input  logic       in_win_i,
    input  logic       commit_i,
    input  logic       sda_chg_i,
    input  logic       scl_chg_i,
    output logic [1:0] code_o,
    output logic       learned_o
);

    logic       all_sda_q, all_scl_q, mv_sda_q, mv_scl_q;
    logic       all_sda_n, all_scl_n, mv_sda_n, mv_scl_n;
    logic [1:0] code_q;
    logic       learned_q;

    assign all_sda_n = all_sda_q & (pin_i == sda_i);
    assign all_scl_n = all_scl_q & (pin_i == scl_i);
    assign mv_sda_n  = mv_sda_q | sda_chg_i;
    assign mv_scl_n  = mv_scl_q | scl_chg_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            all_sda_q <= 1'b0;
            all_scl_q <= 1'b0;
            mv_sda_q  <= 1'b0;
            mv_scl_q  <= 1'b0;
        end else if (start_i) begin
            all_sda_q <= (pin_i == sda_i);
            all_scl_q <= (pin_i == scl_i);
            mv_sda_q  <= 1'b0;
            mv_scl_q  <= 1'b0;
        end else if (in_win_i) begin
            all_sda_q <= all_sda_n;
            all_scl_q <= all_scl_n;
            mv_sda_q  <= mv_sda_n;
            mv_scl_q  <= mv_scl_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q    <= TIE_SUP;
            learned_q <= 1'b0;
        end else if (commit_i && !start_i) begin
            code_q    <= classify_tie(all_sda_n, mv_sda_n, all_scl_n, mv_scl_n, pin_i);
            learned_q <= 1'b1;
        end
    end

    assign code_o    = learned_q ? code_q : {1'b0, pin_i};
    assign learned_o = learned_q;

endmodule

// File: rtl/strap_cfg_map.sv
module strap_cfg_map
    import strap_pkg::*;
#(
    parameter int NUM_PINS = 2,
    parameter int GROUP    = 2,
    localparam int ADDR_W  = 2 * NUM_PINS,
    localparam int CFG_W   = NUM_PINS * GROUP
) (
    input  logic [ADDR_W-1:0] codes_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CFG_W-1:0]  pullup_en_o,
    output logic [CFG_W-1:0]  out_dflt_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic active;
        assign active = (codes_i[2*p +: 2] != TIE_GND);
        assign addr_o[2*p +: 2] = codes_i[2*p +: 2];
        for (genvar g = 0; g < GROUP; g++) begin : g_port
            assign pullup_en_o[p*GROUP + g] = active;
            assign out_dflt_o[p*GROUP + g]  = active;
        end
    end

endmodule

// File: rtl/strap_addr_decoder.sv
module strap_addr_decoder
    import strap_pkg::*;
#(
    parameter int NUM_PINS = 2,
    parameter int GROUP    = 2,
    localparam int ADDR_W  = 2 * NUM_PINS,
    localparam int CFG_W   = NUM_PINS * GROUP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_i,
    input  logic [NUM_PINS-1:0] strap_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CFG_W-1:0]  pullup_en_o,
    output logic [CFG_W-1:0]  out_dflt_o
);

    logic                start_p, commit_p, in_win, sda_chg, scl_chg;
    logic [ADDR_W-1:0]   codes;
    logic [NUM_PINS-1:0] learned;

    strap_bus_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_i     (sda_i),
        .scl_i     (scl_i),
        .start_o   (start_p),
        .commit_o  (commit_p),
        .in_win_o  (in_win),
        .sda_chg_o (sda_chg),
        .scl_chg_o (scl_chg)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_corr
        strap_pin_correlator u_corr (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (strap_i[p]),
            .sda_i     (sda_i),
            .scl_i     (scl_i),
            .start_i   (start_p),
            .in_win_i  (in_win),
            .commit_i  (commit_p),
            .sda_chg_i (sda_chg),
            .scl_chg_i (scl_chg),
            .code_o    (codes[2*p +: 2]),
            .learned_o (learned[p])
        );
    end

    strap_cfg_map #(.NUM_PINS(NUM_PINS), .GROUP(GROUP)) u_map (
        .codes_i     (codes),
        .addr_o      (addr_o),
        .pullup_en_o (pullup_en_o),
        .out_dflt_o  (out_dflt_o)
    );

endmodule

// File: rtl/strap_addr_decoder_chk.sv
module strap_addr_decoder_chk #(
    parameter int NUM_PINS = 2,
    parameter int GROUP    = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_p,
    input logic                     commit_p,
    input logic                     in_win,
    input logic [NUM_PINS-1:0]      learned,
    input logic [2*NUM_PINS-1:0]    addr_o,
    input logic [NUM_PINS*GROUP-1:0] pullup_en_o,
    input logic [NUM_PINS*GROUP-1:0] out_dflt_o
);

    // Learned codes move only on a committing STOP
    assert_commit_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (learned == {NUM_PINS{1'b1}} && $past(learned) == {NUM_PINS{1'b1}}
         && addr_o != $past(addr_o)) |-> $past(commit_p));

    assert_window_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_win) |-> $past(start_p));

    // Stray STOP: outside a window with no START, learning state stays put
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_win && !start_p) |=> $stable(learned));

    assert_unlearned_static_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (learned[0] == 1'b0) |-> (addr_o[1] == 1'b0));

    assert_vectors_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_en_o == out_dflt_o);

    assert_group_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pullup_en_o[1:0] == 2'b00 || pullup_en_o[1:0] == 2'b11)
        && (pullup_en_o[3:2] == 2'b00 || pullup_en_o[3:2] == 2'b11));

endmodule

bind strap_addr_decoder strap_addr_decoder_chk #(.NUM_PINS(NUM_PINS), .GROUP(GROUP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_p     (start_p),
    .commit_p    (commit_p),
    .in_win      (in_win),
    .learned     (learned),
    .addr_o      (addr_o),
    .pullup_en_o (pullup_en_o),
    .out_dflt_o  (out_dflt_o)
);

// File: tb/strap_addr_decoder_tb.sv
`timescale 1ns/1ps
module strap_addr_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sda = 1'b1, scl = 1'b1;
    logic [1:0] mode0 = 2'd1, mode1 = 2'd1;   // 0 gnd, 1 supply, 2 SDA, 3 SCL
    logic [1:0] strap;
    logic [3:0] addr_o, pullup_en_o, out_dflt_o;

    int  checks = 0, failures = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    assign strap[0] = (mode0 == 2'd2) ? sda : (mode0 == 2'd3) ? scl : mode0[0];
    assign strap[1] = (mode1 == 2'd2) ? sda : (mode1 == 2'd3) ? scl : mode1[0];

    strap_addr_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .sda_i(sda), .scl_i(scl), .strap_i(strap),
        .addr_o(addr_o), .pullup_en_o(pullup_en_o), .out_dflt_o(out_dflt_o)
    );

    // ---------------- reference model: sample queue per window ----------------
    int q[$];
    bit m_inx, m_learn, m_sdap, m_sclp, st, sp;
    int m_cls[2];
    int smp;

    task automatic model_commit();
        for (int p = 0; p < 2; p++) begin
            bit ms = 1, mc = 1, ts = 0, tc = 0, lvl;
            for (int i = 0; i < q.size(); i++) begin
                bit pv = q[i][p];
                if (pv != q[i][2]) ms = 0;
                if (pv != q[i][3]) mc = 0;
                if (i > 0 && q[i][2] != q[i-1][2]) ts = 1;
                if (i > 0 && q[i][3] != q[i-1][3]) tc = 1;
            end
            lvl = q[q.size()-1][p];
            m_cls[p] = (ms && ts) ? 2 : (mc && tc) ? 3 : (lvl ? 1 : 0);
        end
    endtask

    function automatic logic [3:0] exp_addr();
        int c0 = m_learn ? m_cls[0] : int'(strap[0]);
        int c1 = m_learn ? m_cls[1] : int'(strap[1]);
        return {c1[1:0], c0[1:0]};
    endfunction

    function automatic logic [3:0] exp_cfg();
        logic [3:0] a = exp_addr();
        return {{2{a[3:2] != 2'b00}}, {2{a[1:0] != 2'b00}}};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_inx = 0; m_learn = 0; m_sdap = 1; m_sclp = 1;
        end else begin
            st  = scl && m_sclp && m_sdap && !sda;
            sp  = scl && m_sclp && !m_sdap && sda;
            smp = {28'd0, scl, sda, strap[1], strap[0]};
            if (st) begin
                q.delete(); q.push_back(smp); m_inx = 1;
            end else if (m_inx) begin
                q.push_back(smp);
                if (sp) begin model_commit(); m_inx = 0; m_learn = 1; end
            end
            m_sdap = sda; m_sclp = scl;
        end
        #1;
        if (rst_n && !done) begin
            checks++;
            if (addr_o !== exp_addr()) begin
                failures++;
                $display("FAIL R6 model addr actual=%b expected=%b", addr_o, exp_addr());
            end
            checks++;
            if (pullup_en_o !== exp_cfg() || out_dflt_o !== exp_cfg()) begin
                failures++;
                $display("FAIL R7 model cfg actual=%b/%b expected=%b",
                         pullup_en_o, out_dflt_o, exp_cfg());
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda = 1; scl = 1; tick(2);
        sda = 0; tick(2);
        scl = 0; tick(1);
    endtask

    task automatic bus_rstart();
        sda = 1; tick(1); scl = 1; tick(1);
        sda = 0; tick(2); scl = 0; tick(1);
    endtask

    task automatic bus_bit(bit b);
        sda = b; tick(1); scl = 1; tick(2); scl = 0; tick(1);
    endtask

    task automatic bus_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
        bus_bit(1'b0);
    endtask

    task automatic bus_stop();
        sda = 0; tick(1); scl = 1; tick(1); sda = 1; tick(2);
    endtask

    initial begin
        mode0 = 2'd2; mode1 = 2'd0;
        tick(3); rst_n = 1; tick(2);
        // R1: SDA-tied pin idles high -> 01, ground pin -> 00
        check("R1 reset addr", addr_o, 4'b0001);
        check("R7 reset pullup", pullup_en_o, 4'b0011);
        check("R7 reset default", out_dflt_o, 4'b0011);

        // R3/R4: pin0 on SDA, pin1 on SCL
        mode0 = 2'd2; mode1 = 2'd3;
        bus_start(); bus_byte(8'hA5); bus_byte(8'h3C); bus_stop();
        check("R3 R4 R6 sda/scl tie", addr_o, 4'b1110);
        check("R7 all pullups", pullup_en_o, 4'b1111);

        // R2: codes hold inside a window; R5 static levels
        mode0 = 2'd1; mode1 = 2'd0;
        bus_start(); bus_byte(8'h5A);
        check("R2 held mid-window", addr_o, 4'b1110);
        bus_stop();
        check("R5 R6 supply/ground", addr_o, 4'b0001);
        check("R7 half pullups", pullup_en_o, 4'b0011);

        // R5: START straight into STOP, SCL never pulses
        mode0 = 2'd2; mode1 = 2'd3;
        sda = 1; scl = 1; tick(2); sda = 0; tick(2); sda = 1; tick(2);
        check("R5 no scl pulse", addr_o, 4'b0110);

        // R8: stray STOP with no window
        mode0 = 2'd0; mode1 = 2'd0;
        scl = 0; tick(1); sda = 0; tick(1); scl = 1; tick(1); sda = 1; tick(2);
        check("R8 stray stop ignored", addr_o, 4'b0110);
        bus_start(); bus_byte(8'h96); bus_stop();
        check("R5 both ground", addr_o, 4'b0000);
        check("R7 no pullups", out_dflt_o, 4'b0000);

        // R8: repeated START restarts the window
        mode0 = 2'd3; mode1 = 2'd2;
        bus_start(); bus_byte(8'hC3);
        bus_rstart(); bus_byte(8'h69); bus_stop();
        check("R8 repeated start", addr_o, 4'b1011);

        // R9: reset returns to the unlearned state
        mode0 = 2'd3; mode1 = 2'd0;
        rst_n = 0; tick(2); rst_n = 1; tick(2);
        check("R9 reset unlearned", addr_o, 4'b0001);
        check("R9 reset pullup", pullup_en_o, 4'b0011);

        tick(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule